// File: doc/BRIEF.md
# Split-Register Performance Monitor

This block counts hardware activity for profiling. It holds one free-running cycle counter and four event counters, all 32 bits wide. Each event counter follows one line of the `evt_i` bus, and an 8-bit select code picks that line. Control, overflow flags, interrupt enables and the select codes each sit in their own register. The flag and enable registers share one layout: one bit per counter, with the cycle counter at bit 0 and event counter k at bit k+1.

Software reaches every register through a simple word-addressed port. A write happens in the cycle that `reg_we_i` is high. A read needs no strobe: the data for the address presented in one cycle appears on `reg_rdata_o` after the next clock edge. A counter that wraps sets its flag. The level interrupt stays high while any set flag has its enable bit set.

Top module: `perfmon_split`

## Requirements
- R1: After the synchronous reset, all five counters, the flags, the enables and the control enable and divide bits read 0. The select register reads 0xFFFFFFFF, and `irq_o` is low.
- R2: The control register is at address 0. Bit 0 (count enable) and bit 3 (cycle divide-by-64) read back as written. Bits 1, 2 and 4–23 always read 0. Bits 24–31 always read the identification constant 0x14, whatever value was written to them.
- R3: While bit 0 of the control register is set, the cycle counter (address 4) adds one on every clock edge. With bit 3 also set, it adds one only on every 64th enabled edge. While bit 0 is clear, no counter changes.
- R4: The select register is at address 3. Event counter k (address 5+k, k = 0..3) takes its code from bits 8k+7..8k. It adds one on an edge where counting is enabled, the code c is below the number of event lines, and `evt_i[c]` is 1.
- R5: An event counter whose code is 0xFF, or any value not below the number of event lines, never counts.
- R6: A counter that steps from 0xFFFFFFFF goes to 0 and sets its flag on the same edge. The flag register is at address 1: bit 0 is the cycle counter and bit 1+k is event counter k.
- R7: A write to the flag register clears each flag whose data bit is 1 and leaves the others unchanged. A wrap in the same cycle as a clear leaves that flag set.
- R8: Writing control bit 1 zeroes the four event counters. Writing control bit 2 zeroes the cycle counter and its divide prescaler. Both take effect on that edge, win over a same-cycle increment, and leave the flags unchanged.
- R9: A write to a counter address loads the written value. It overrides any increment in the same cycle, and that dropped increment sets no flag.
- R10: The enable register is at address 2 and uses the flag layout, bits 0–4. `irq_o` equals the OR of (flags AND enables) as they stand after each edge.
- R11: `reg_rdata_o` shows, one edge after an address is presented, the value that register held before that edge. Addresses 9–15 read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| evt_i | input | NUM_EVT_SRC | Event lines, sampled on each edge |
| reg_we_i | input | 1 | Register write strobe |
| reg_addr_i | input | 4 | Register word address |
| reg_wdata_i | input | 32 | Register write data |
| reg_rdata_o | output | 32 | Registered read data for the previous cycle's address |
| irq_o | output | 1 | Registered level interrupt |

## Verification
Counter values, flags, enables and `irq_o` all change on the edge that samples the stimulus. They can be seen just after that edge, except through `reg_rdata_o`, which reports state from before the edge and so lags by one cycle. The bench drives inputs at the falling edge and steps a behavioural model through the same edge. It then compares both outputs at the next falling edge. This keeps each read one cycle behind its address, and it checks the interrupt in the same cycle as the flag change. The 64-cycle prescaler, the wrap cases and the same-cycle races (clear against set, load against increment, counter reset against increment) are all placed on specific cycles and compared there.

// File: rtl/perfmon_pkg.sv
package perfmon_pkg;
  localparam int SEL_W       = 8;
  localparam int NUM_EVT_CNT = 4;
  localparam int ADDR_W      = 4;

  localparam logic [ADDR_W-1:0] ADR_CTL = 4'd0;
  localparam logic [ADDR_W-1:0] ADR_OVF = 4'd1;
  localparam logic [ADDR_W-1:0] ADR_IEN = 4'd2;
  localparam logic [ADDR_W-1:0] ADR_SEL = 4'd3;
  localparam int                CNT_BASE = 4;   // cycle counter, then event counters

  localparam int CTL_EN    = 0;
  localparam int CTL_EVRST = 1;
  localparam int CTL_CYRST = 2;
  localparam int CTL_DIV   = 3;
endpackage

// File: rtl/pm_evsel.sv
// Picks one event line by code; codes at or above N_SRC match nothing.
// N_SRC must stay below 2**SEL_W - 1 so the all-ones code never matches.
module pm_evsel #(
  parameter int N_SRC = 32,
  parameter int SEL_W = 8
) (
  input  logic [SEL_W-1:0] code_i,
  input  logic [N_SRC-1:0] evt_i,
  output logic             hit_o
);
  always_comb begin
    hit_o = 1'b0;
    for (int i = 0; i < N_SRC; i++)
      if (code_i == SEL_W'(i)) hit_o = evt_i[i];
  end
endmodule

// File: rtl/pm_counter.sv
module pm_counter #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         ld_i,
  input  logic [W-1:0] ld_val_i,
  input  logic         clr_i,
  input  logic         inc_i,
  output logic [W-1:0] cnt_o,
  output logic         wrap_o
);
  logic [W-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst)        cnt_q <= '0;
    else if (ld_i)  cnt_q <= ld_val_i;
    else if (clr_i) cnt_q <= '0;
    else if (inc_i) cnt_q <= cnt_q + 1'b1;
  end

  assign cnt_o  = cnt_q;
  assign wrap_o = inc_i && !ld_i && !clr_i && (cnt_q == '1);

  a_r9_load_wins: assert property (@(posedge clk) disable iff (rst)
    ld_i |=> cnt_q == $past(ld_val_i));
  a_r8_clear_zero: assert property (@(posedge clk) disable iff (rst)
    (clr_i && !ld_i) |=> cnt_q == '0);
  a_r3_hold_idle: assert property (@(posedge clk) disable iff (rst)
    (!ld_i && !clr_i && !inc_i) |=> $stable(cnt_q));
  a_r6_wrap_zero: assert property (@(posedge clk) disable iff (rst)
    wrap_o |=> cnt_q == '0);
endmodule

// File: rtl/perfmon_split.sv
module perfmon_split
  import perfmon_pkg::*;
#(
  parameter int         CNT_W       = 32,
  parameter int         NUM_EVT_SRC = 32,
  parameter int         PRE_W       = 6,
  parameter logic [7:0] ID_CODE     = 8'h14
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic [NUM_EVT_SRC-1:0] evt_i,
  input  logic                   reg_we_i,
  input  logic [ADDR_W-1:0]      reg_addr_i,
  input  logic [31:0]            reg_wdata_i,
  output logic [31:0]            reg_rdata_o,
  output logic                   irq_o
);
  localparam int NUM_CNT = NUM_EVT_CNT + 1;
  localparam int DATA_W  = NUM_EVT_CNT * SEL_W;

  logic               en_q, div_q;
  logic [NUM_CNT-1:0] ien_q, ovf_q, ovf_d, ien_d, ovf_clr;
  logic [DATA_W-1:0]  sel_q;
  logic [PRE_W-1:0]   pre_q;
  logic [DATA_W-1:0]  rdata_q, rd_mux;
  logic               irq_q;

  logic [NUM_CNT-1:0] ld, clr, inc, wrap;
  logic [CNT_W-1:0]   cnt [NUM_CNT];

  logic wr_ctl, wr_ovf, wr_ien, wr_sel, cyc_tick;
  assign wr_ctl = reg_we_i && (reg_addr_i == ADR_CTL);
  assign wr_ovf = reg_we_i && (reg_addr_i == ADR_OVF);
  assign wr_ien = reg_we_i && (reg_addr_i == ADR_IEN);
  assign wr_sel = reg_we_i && (reg_addr_i == ADR_SEL);

  assign cyc_tick = en_q && (!div_q || (pre_q == '1));

  always_ff @(posedge clk) begin
    if (rst)                pre_q <= '0;
    else if (clr[0])        pre_q <= '0;
    else if (en_q && div_q) pre_q <= pre_q + 1'b1;
    else                    pre_q <= '0;
  end

  for (genvar g = 0; g < NUM_CNT; g++) begin : g_cnt
    assign ld[g] = reg_we_i && (reg_addr_i == ADDR_W'(CNT_BASE + g));
    if (g == 0) begin : g_cyc
      assign clr[g] = wr_ctl && reg_wdata_i[CTL_CYRST];
      assign inc[g] = cyc_tick;
    end else begin : g_evt
      logic hit;
      pm_evsel #(.N_SRC(NUM_EVT_SRC), .SEL_W(SEL_W)) u_sel (
        .code_i(sel_q[(g-1)*SEL_W +: SEL_W]),
        .evt_i (evt_i),
        .hit_o (hit)
      );
      assign clr[g] = wr_ctl && reg_wdata_i[CTL_EVRST];
      assign inc[g] = en_q && hit;
    end

    pm_counter #(.W(CNT_W)) u_cnt (
      .clk     (clk),
      .rst     (rst),
      .ld_i    (ld[g]),
      .ld_val_i(CNT_W'(reg_wdata_i)),
      .clr_i   (clr[g]),
      .inc_i   (inc[g]),
      .cnt_o   (cnt[g]),
      .wrap_o  (wrap[g])
    );

    a_r6_wrap_sets_flag: assert property (@(posedge clk) disable iff (rst)
      wrap[g] |=> ovf_q[g]);
    a_r7_flag_clear: assert property (@(posedge clk) disable iff (rst)
      (wr_ovf && reg_wdata_i[g] && !wrap[g]) |=> !ovf_q[g]);
  end

  assign ovf_clr = wr_ovf ? reg_wdata_i[NUM_CNT-1:0] : '0;
  assign ovf_d   = (ovf_q & ~ovf_clr) | wrap;
  assign ien_d   = wr_ien ? reg_wdata_i[NUM_CNT-1:0] : ien_q;

  always_comb begin
    rd_mux = '0;
    case (reg_addr_i)
      ADR_CTL: begin
        rd_mux[DATA_W-1 -: 8] = ID_CODE;
        rd_mux[CTL_EN]        = en_q;
        rd_mux[CTL_DIV]       = div_q;
      end
      ADR_OVF: rd_mux[NUM_CNT-1:0] = ovf_q;
      ADR_IEN: rd_mux[NUM_CNT-1:0] = ien_q;
      ADR_SEL: rd_mux = sel_q;
      default: ;
    endcase
    for (int i = 0; i < NUM_CNT; i++)
      if (reg_addr_i == ADDR_W'(CNT_BASE + i)) rd_mux = DATA_W'(cnt[i]);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      en_q    <= 1'b0;
      div_q   <= 1'b0;
      ien_q   <= '0;
      sel_q   <= '1;
      ovf_q   <= '0;
      irq_q   <= 1'b0;
      rdata_q <= '0;
    end else begin
      if (wr_ctl) begin
        en_q  <= reg_wdata_i[CTL_EN];
        div_q <= reg_wdata_i[CTL_DIV];
      end
      if (wr_sel) sel_q <= reg_wdata_i[DATA_W-1:0];
      ien_q   <= ien_d;
      ovf_q   <= ovf_d;
      irq_q   <= |(ovf_d & ien_d);
      rdata_q <= rd_mux;
    end
  end

  assign reg_rdata_o = rdata_q;
  assign irq_o       = irq_q;

  a_r10_irq_level: assert property (@(posedge clk) disable iff (rst)
    irq_o == |(ovf_q & ien_q));
  a_r2_ctl_fixed_bits: assert property (@(posedge clk) disable iff (rst)
    (reg_addr_i == ADR_CTL) |=> (reg_rdata_o[31:24] == ID_CODE) && (reg_rdata_o[2:1] == 2'b00));
endmodule

// File: tb/sim_perfmon_split.sv
`timescale 1ns/1ps
module sim_perfmon_split;
  localparam int NEV = 32;

  logic           clk = 1'b0;
  logic           rst = 1'b1;
  logic [NEV-1:0] evt = '0;
  logic           we = 1'b0;
  logic [3:0]     addr = '0;
  logic [31:0]    wdata = '0;
  logic [31:0]    rdata;
  logic           irq;

  always #10 clk = ~clk;

  perfmon_split #(.NUM_EVT_SRC(NEV)) u0 (
    .clk(clk), .rst(rst), .evt_i(evt), .reg_we_i(we), .reg_addr_i(addr),
    .reg_wdata_i(wdata), .reg_rdata_o(rdata), .irq_o(irq)
  );

  int    n_chk = 0, n_fail = 0;
  string req = "R1";

  bit [31:0] m_cnt [5];
  bit        m_en = 0, m_div = 0;
  int        m_pre = 0;
  bit [4:0]  m_ien = 0, m_ovf = 0;
  bit [31:0] m_sel = 32'hFFFF_FFFF;
  bit [31:0] x_rd = 0;
  bit        x_irq = 0;

  function automatic bit [31:0] m_read(input bit [3:0] a);
    case (a)
      4'd0: return {8'h14, 20'h0, m_div, 2'b00, m_en};
      4'd1: return {27'h0, m_ovf};
      4'd2: return {27'h0, m_ien};
      4'd3: return m_sel;
      4'd4, 4'd5, 4'd6, 4'd7, 4'd8: return m_cnt[a - 4];
      default: return 32'h0;
    endcase
  endfunction

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s at %0t: actual %h expected %h", tag, $time, act, exp);
    end
  endtask

  task automatic model_step(input bit w, input bit [3:0] a, input bit [31:0] d, input bit [NEV-1:0] e);
    bit [4:0] inc, wrp;
    bit [7:0] code;
    x_rd   = m_read(a);
    wrp    = '0;
    inc[0] = m_en && (!m_div || m_pre == 63);
    for (int k = 0; k < 4; k++) begin
      code       = m_sel[8*k +: 8];
      inc[k + 1] = m_en && (code < NEV) && e[code[4:0]];
    end
    if (w && a == 0 && d[2])  m_pre = 0;
    else if (m_en && m_div)   m_pre = (m_pre + 1) % 64;
    else                      m_pre = 0;
    for (int i = 0; i < 5; i++) begin
      if (w && a == 4 + i)                        m_cnt[i] = d;
      else if (w && a == 0 && d[(i == 0) ? 2 : 1]) m_cnt[i] = 0;
      else if (inc[i]) begin
        if (m_cnt[i] == 32'hFFFF_FFFF) wrp[i] = 1'b1;
        m_cnt[i] = m_cnt[i] + 1;
      end
    end
    if (w && a == 1) m_ovf = m_ovf & ~d[4:0];
    m_ovf = m_ovf | wrp;
    if (w && a == 0) begin m_en = d[0]; m_div = d[3]; end
    if (w && a == 2) m_ien = d[4:0];
    if (w && a == 3) m_sel = d;
    x_irq = |(m_ovf & m_ien);
  endtask

  task automatic cyc(input bit w, input bit [3:0] a, input bit [31:0] d, input bit [NEV-1:0] e);
    we = w; addr = a; wdata = d; evt = e;
    model_step(w, a, d, e);
    @(negedge clk);
    check(req, rdata, x_rd);
    check("R10", {31'h0, irq}, {31'h0, x_irq});
  endtask

  task automatic rd(input bit [3:0] a);
    cyc(1'b0, a, 32'h0, '0);
  endtask

  task automatic wr(input bit [3:0] a, input bit [31:0] d);
    cyc(1'b1, a, d, '0);
  endtask

  task automatic finish_run;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  initial begin
    #(200000 * 20);
    n_fail++;
    $display("FAIL %s watchdog: actual running expected finished", req);
    finish_run();
  end

  initial begin
    for (int i = 0; i < 5; i++) m_cnt[i] = 0;
    repeat (3) @(negedge clk);
    // R1: outputs held at zero during reset
    check("R1", rdata, 32'h0);
    check("R1", {31'h0, irq}, 32'h0);
    rst = 1'b0;

    req = "R1";
    for (int a = 0; a < 9; a++) rd(4'(a));
    req = "R11";
    rd(4'd9); rd(4'd15); rd(4'd3); rd(4'd0);

    req = "R2";
    wr(4'd0, 32'hABCD_EF07);
    rd(4'd0); rd(4'd0); rd(4'd1);

    req = "R3";
    repeat (10) rd(4'd4);

    req = "R4";
    wr(4'd3, 32'h1F28_FF05);
    for (int i = 0; i < 60; i++) cyc(1'b0, 4'(4 + (i % 5)), 32'h0, $urandom);
    req = "R5";
    for (int i = 0; i < 16; i++) cyc(1'b0, 4'(6 + (i % 2)), 32'h0, '1);

    req = "R3";
    wr(4'd0, 32'h0000_0009);
    for (int i = 0; i < 140; i++) rd(4'd4);
    wr(4'd0, 32'h0000_0001);
    rd(4'd4); rd(4'd4);

    req = "R6";
    wr(4'd2, 32'h0000_001F);
    wr(4'd4, 32'hFFFF_FFF0);
    for (int i = 0; i < 20; i++) rd(4'd1);
    wr(4'd8, 32'hFFFF_FFFE);
    for (int i = 0; i < 4; i++) cyc(1'b0, 4'd8, 32'h0, 32'h8000_0000);
    rd(4'd1); rd(4'd1);

    req = "R7";
    wr(4'd1, 32'h0000_0001);
    rd(4'd1); rd(4'd1);
    wr(4'd8, 32'hFFFF_FFFF);
    cyc(1'b1, 4'd1, 32'h0000_0010, 32'h8000_0000);
    rd(4'd1); rd(4'd1);
    wr(4'd1, 32'h0000_001F);
    rd(4'd1); rd(4'd1);

    req = "R8";
    for (int i = 0; i < 4; i++) cyc(1'b0, 4'(5 + i), 32'h0, '1);
    wr(4'd8, 32'hFFFF_FFFF);
    cyc(1'b1, 4'd0, 32'h0000_0003, '1);
    for (int i = 0; i < 4; i++) rd(4'(5 + i));
    rd(4'd1);
    cyc(1'b1, 4'd0, 32'h0000_0005, '1);
    rd(4'd4); rd(4'd4); rd(4'd0); rd(4'd1);

    req = "R9";
    cyc(1'b1, 4'd8, 32'h0000_1234, 32'h8000_0000);
    rd(4'd8); rd(4'd8);
    wr(4'd1, 32'h0000_001F);
    cyc(1'b1, 4'd8, 32'hFFFF_FFFF, 32'h8000_0000);
    rd(4'd1); cyc(1'b0, 4'd1, 32'h0, 32'h8000_0000); rd(4'd1); rd(4'd8);

    req = "R10";
    wr(4'd2, 32'h0000_0000);
    rd(4'd2);
    wr(4'd2, 32'h0000_0010);
    rd(4'd2);
    wr(4'd1, 32'h0000_001F);
    rd(4'd1); rd(4'd2);

    req = "R3";
    wr(4'd0, 32'h0000_0000);
    for (int i = 0; i < 10; i++) cyc(1'b0, 4'(4 + (i % 5)), 32'h0, '1);

    finish_run();
  end
endmodule